// File: doc/BRIEF.md
# LCD Controller Register Interface

This block is the software-visible register file of a simple LCD controller. It sits on a 32-bit valid-strobe register bus with a 256-byte window and holds six word registers: control, three timing words, status and subpanel. Register writes are split into fields that go to the rest of the controller: the panel load mode, the TFT and mono selects, a 2-bit interrupt enable mask, and the panel width and height, each held as the value minus one.

A change of the enable bit in the control register raises a one-cycle start or stop pulse for the frame fetch sequencer. That sequencer reports back through three set pulses (frame done, palette loaded, sync error). These set sticky status flags, and the flags drive one level-sensitive interrupt line. A sync error raises the interrupt whatever the enable mask holds. Several readbacks carry fixed constant bits ORed into the stored fields. Pixel fetch and drawing are done elsewhere.

Top module: `panel_csr`

## Requirements
- R1: After reset every stored field and flag is zero. The control word reads 0xFE000C34, timing 0 reads 0x0000000F, timing 2 reads 0xFC000000, and timing 1, status and subpanel read 0. The irq output and both pulses are low.
- R2: A read strobe (bus_valid high, bus_write low) gives bus_rvalid high with the data in the next cycle. A write strobe never raises bus_rvalid.
- R3: A write to control (offset 0x00) stores load mode from bits 21:20, TFT from bit 7, interrupt enables from bits 4:3 and mono from bit 1. All other bits are kept only where the mask 0x01CFF300 is set. The control word reads back as TFT at bits 23 and 7, load mode at 21:20, enables at 4:3, mono at 1, enable at 0, ORed with the kept bits and with 0xFE000C34.
- R4: Timing 0 (offset 0x04) bits 9:0 give width_m1 and timing 1 (offset 0x08) bits 9:0 give height_m1. Bits 31:10 of both are kept unchanged. Timing 0 reads back ORed with 0x0000000F, and timing 1 reads back as written.
- R5: Timing 2 (offset 0x0C) stores the full word and reads back ORed with 0xFC000000.
- R6: A write to subpanel (offset 0x14) keeps only the bits under the mask 0xA1FFFFFF.
- R7: Status (offset 0x10) reads palette-done at bit 6, sync-error at bit 2 and frame-done at bit 0, with all other bits zero. A write to status changes nothing.
- R8: A control write whose bit 0 differs from the current enable loads the new enable. In the next cycle it raises start_pulse (new value 1) or stop_pulse (new value 0) for exactly one cycle. A control write that leaves bit 0 unchanged raises no pulse.
- R9: On a disable transition, sync-error is cleared and frame-done is set, unless the load mode being written is 1, in which case frame-done keeps its value.
- R10: On an enable transition, frame-done and palette-done are cleared.
- R11: irq is high when frame-done is set with enable bit 0 (control bit 3), or palette-done is set with enable bit 1 (control bit 4), or sync-error is set whatever the enables hold. Otherwise it is low.
- R12: An access to an offset outside the six registers, or one whose address bits 1:0 are not zero, reads as zero and leaves every register unchanged.
- R13: A set pulse on set_frame_done, set_palette_done or set_sync_error sets the matching flag. The flag stays set until a control transition clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | Access strobe |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 8 | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read strobe |
| set_frame_done | input | 1 | Sequencer pulse: frame finished |
| set_palette_done | input | 1 | Sequencer pulse: palette loaded |
| set_sync_error | input | 1 | Sequencer pulse: synchronisation error |
| load_mode | output | 2 | Panel load mode field |
| tft_sel | output | 1 | TFT panel select |
| mono_sel | output | 1 | Monochrome select |
| width_m1 | output | 10 | Panel width minus one |
| height_m1 | output | 10 | Panel height minus one |
| run_en | output | 1 | Current enable state |
| start_pulse | output | 1 | One-cycle start event |
| stop_pulse | output | 1 | One-cycle stop event |
| irq | output | 1 | Level interrupt |

## Verification
The bench reads back every register after patterns that fill the fixed constant bits. A design that forgot an OR constant or a write mask would return the raw written word. It writes the status register with all ones after the flags are set, which catches a design that lets software clear or set flags by writing. It clears the enable mask while sync-error is set: a design that gated sync-error with a mask bit would drop irq. It also disables with load mode 1 and 0, and rewrites the same enable value, which catches a spurious frame-done or a pulse raised on every control write.

// File: rtl/panel_csr_pkg.sv
// Shared constants and types for the LCD controller register interface.
// Assumes a 32-bit data bus and word-aligned register offsets.
package panel_csr_pkg;

    localparam int CSR_DATA_W = 32;
    localparam int CSR_DIM_W  = 10;
    localparam int CSR_HI_W   = CSR_DATA_W - CSR_DIM_W;

    localparam logic [CSR_DATA_W-1:0] CTRL_KEEP_MASK = 32'h01CF_F300;
    localparam logic [CSR_DATA_W-1:0] CTRL_RD_ONES   = 32'hFE00_0C34;
    localparam logic [CSR_DATA_W-1:0] TIM0_RD_ONES   = 32'h0000_000F;
    localparam logic [CSR_DATA_W-1:0] TIM2_RD_ONES   = 32'hFC00_0000;
    localparam logic [CSR_DATA_W-1:0] SUBP_MASK      = 32'hA1FF_FFFF;

    typedef enum logic [2:0] {
        SEL_CTRL, SEL_TIM0, SEL_TIM1, SEL_TIM2, SEL_STAT, SEL_SUBP, SEL_NONE
    } csr_sel_e;

    typedef struct packed {
        logic [1:0]            load_mode;
        logic                  tft;
        logic [1:0]            int_en;
        logic                  mono;
        logic [CSR_DATA_W-1:0] ctrl_keep;
        logic [CSR_HI_W-1:0]   tim0_hi;
        logic [CSR_DIM_W-1:0]  width_m1;
        logic [CSR_HI_W-1:0]   tim1_hi;
        logic [CSR_DIM_W-1:0]  height_m1;
        logic [CSR_DATA_W-1:0] tim2;
        logic [CSR_DATA_W-1:0] subpanel;
    } csr_cfg_t;

    // Maps a byte offset to a register select; misaligned or unknown gives SEL_NONE.
    function automatic csr_sel_e csr_decode(input logic [7:0] a);
        if (a[1:0] != 2'b00) return SEL_NONE;
        case (a[7:2])
            6'd0:    return SEL_CTRL;
            6'd1:    return SEL_TIM0;
            6'd2:    return SEL_TIM1;
            6'd3:    return SEL_TIM2;
            6'd4:    return SEL_STAT;
            6'd5:    return SEL_SUBP;
            default: return SEL_NONE;
        endcase
    endfunction

endpackage

// File: rtl/panel_csr_cfg.sv
// Configuration storage: control fields, timing words and subpanel.
// Assumes one write strobe per cycle; status and unknown selects store nothing.
module panel_csr_cfg
    import panel_csr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  csr_sel_e              wr_sel,
    input  logic [CSR_DATA_W-1:0] wdata,
    output csr_cfg_t              cfg
);

    // Capture write data into the selected register's fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CTRL: begin
                    cfg.load_mode <= wdata[21:20];
                    cfg.tft       <= wdata[7];
                    cfg.int_en    <= wdata[4:3];
                    cfg.mono      <= wdata[1];
                    cfg.ctrl_keep <= wdata & CTRL_KEEP_MASK;
                end
                SEL_TIM0: begin
                    cfg.tim0_hi  <= wdata[CSR_DATA_W-1:CSR_DIM_W];
                    cfg.width_m1 <= wdata[CSR_DIM_W-1:0];
                end
                SEL_TIM1: begin
                    cfg.tim1_hi   <= wdata[CSR_DATA_W-1:CSR_DIM_W];
                    cfg.height_m1 <= wdata[CSR_DIM_W-1:0];
                end
                SEL_TIM2: cfg.tim2     <= wdata;
                SEL_SUBP: cfg.subpanel <= wdata & SUBP_MASK;
                default:  ;
            endcase
        end
    end

    // R7 / R12: writes to status or an unknown offset leave the stored fields alone.
    p_no_store_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_sel == SEL_STAT || wr_sel == SEL_NONE)) |=> $stable(cfg));

    // R6: reserved subpanel bits can never hold a one.
    p_subp_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.subpanel & ~SUBP_MASK) == '0);

endmodule

// File: rtl/panel_csr_flags.sv
// Enable state, start/stop event pulses, sticky status flags and interrupt.
// Assumes set pulses come from the fetch sequencer; a control transition
// in the same cycle takes priority over a set pulse for the flag it clears.
module panel_csr_flags
    import panel_csr_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctrl_wr,
    input  logic       new_en,
    input  logic [1:0] new_load_mode,
    input  logic [1:0] int_en,
    input  logic       set_fd,
    input  logic       set_pd,
    input  logic       set_se,
    output logic       run_en,
    output logic       start_pulse,
    output logic       stop_pulse,
    output logic       frame_done,
    output logic       palette_done,
    output logic       sync_err,
    output logic       irq
);

    logic going_on;
    logic going_off;
    logic fd_nxt;
    logic pd_nxt;
    logic se_nxt;

    // Detect enable transitions carried by a control write.
    always_comb begin
        going_on  = ctrl_wr &&  new_en && !run_en;
        going_off = ctrl_wr && !new_en &&  run_en;
    end

    // Next flag values: transition effects first, otherwise set pulses accumulate.
    always_comb begin
        if (going_on)
            fd_nxt = 1'b0;
        else if (going_off && new_load_mode != 2'd1)
            fd_nxt = 1'b1;
        else
            fd_nxt = frame_done | set_fd;
        pd_nxt = going_on  ? 1'b0 : (palette_done | set_pd);
        se_nxt = going_off ? 1'b0 : (sync_err | set_se);
    end

    // Register the enable, the event pulses and the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_en       <= 1'b0;
            start_pulse  <= 1'b0;
            stop_pulse   <= 1'b0;
            frame_done   <= 1'b0;
            palette_done <= 1'b0;
            sync_err     <= 1'b0;
        end else begin
            start_pulse  <= going_on;
            stop_pulse   <= going_off;
            if (going_on || going_off)
                run_en <= new_en;
            frame_done   <= fd_nxt;
            palette_done <= pd_nxt;
            sync_err     <= se_nxt;
        end
    end

    // Priority combine: sync error first and unmasked, then masked done flags.
    always_comb begin
        if (sync_err)
            irq = 1'b1;
        else if (frame_done && int_en[0])
            irq = 1'b1;
        else
            irq = palette_done && int_en[1];
    end

    // R8: event pulses last one cycle and agree with the new enable.
    p_start_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |=> !start_pulse);
    p_stop_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |=> !stop_pulse);
    p_start_en_r8: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> run_en);
    p_pulse_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pulse, stop_pulse}));
    // R9: a stop leaves sync-error clear.
    p_stop_sync_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_pulse |-> !sync_err);
    // R10: a start leaves both done flags clear.
    p_start_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> (!frame_done && !palette_done));
    // R11: sync-error forces the interrupt; nothing else does with the mask off.
    p_sync_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        sync_err |-> irq);
    p_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (int_en == 2'b00 && !sync_err) |-> !irq);
    // R13: a set flag stays set unless a control write arrives.
    p_fd_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_done && !ctrl_wr) |=> frame_done);
    p_se_sticky_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_err && !ctrl_wr) |=> sync_err);

endmodule

// File: rtl/panel_csr_rdmux.sv
// Readback formatter and registered read port.
// Assumes reads return one cycle after the strobe with no back-pressure.
module panel_csr_rdmux
    import panel_csr_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  rd_en,
    input  csr_sel_e              rd_sel,
    input  csr_cfg_t              cfg,
    input  logic                  run_en,
    input  logic                  frame_done,
    input  logic                  palette_done,
    input  logic                  sync_err,
    output logic [CSR_DATA_W-1:0] rdata,
    output logic                  rvalid
);

    logic [CSR_DATA_W-1:0] word;

    // Assemble the readback word of the selected register.
    always_comb begin
        word = '0;
        case (rd_sel)
            SEL_CTRL: begin
                word        = cfg.ctrl_keep | CTRL_RD_ONES;
                word[23]    = word[23] | cfg.tft;
                word[21:20] = word[21:20] | cfg.load_mode;
                word[7]     = word[7] | cfg.tft;
                word[4:3]   = word[4:3] | cfg.int_en;
                word[1]     = word[1] | cfg.mono;
                word[0]     = word[0] | run_en;
            end
            SEL_TIM0: word = {cfg.tim0_hi, cfg.width_m1} | TIM0_RD_ONES;
            SEL_TIM1: word = {cfg.tim1_hi, cfg.height_m1};
            SEL_TIM2: word = cfg.tim2 | TIM2_RD_ONES;
            SEL_STAT: begin
                word[6] = palette_done;
                word[2] = sync_err;
                word[0] = frame_done;
            end
            SEL_SUBP: word = cfg.subpanel;
            default:  word = '0;
        endcase
    end

    // Register the read response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata  <= '0;
            rvalid <= 1'b0;
        end else begin
            rvalid <= rd_en;
            if (rd_en)
                rdata <= word;
        end
    end

    // R2: a response follows every read strobe and nothing else.
    p_rvalid_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rvalid);
    p_no_spurious_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rvalid);
    // R12: unknown offsets read as zero.
    p_unknown_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rd_sel == SEL_NONE) |=> (rdata == '0));

endmodule

// File: rtl/panel_csr.sv
// Top of the LCD controller register interface: decode, storage, flags, readback.
// Assumes a valid-strobe bus where each strobed cycle is one full-word access.
module panel_csr
    import panel_csr_pkg::*;
#(
    parameter int ADDR_W = 8
)(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  bus_valid,
    input  logic                  bus_write,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic [CSR_DATA_W-1:0] bus_wdata,
    output logic [CSR_DATA_W-1:0] bus_rdata,
    output logic                  bus_rvalid,
    input  logic                  set_frame_done,
    input  logic                  set_palette_done,
    input  logic                  set_sync_error,
    output logic [1:0]            load_mode,
    output logic                  tft_sel,
    output logic                  mono_sel,
    output logic [CSR_DIM_W-1:0]  width_m1,
    output logic [CSR_DIM_W-1:0]  height_m1,
    output logic                  run_en,
    output logic                  start_pulse,
    output logic                  stop_pulse,
    output logic                  irq
);

    csr_sel_e sel;
    csr_cfg_t cfg;
    logic     wr_en;
    logic     rd_en;
    logic     ctrl_wr;
    logic     fd;
    logic     pd;
    logic     se;

    // Decode the access into a register select and strobes.
    always_comb begin
        sel     = csr_decode(8'(bus_addr));
        wr_en   = bus_valid &&  bus_write;
        rd_en   = bus_valid && !bus_write;
        ctrl_wr = wr_en && sel == SEL_CTRL;
    end

    panel_csr_cfg u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .wr_sel (sel),
        .wdata  (bus_wdata),
        .cfg    (cfg)
    );

    panel_csr_flags u_flags (
        .clk           (clk),
        .rst_n         (rst_n),
        .ctrl_wr       (ctrl_wr),
        .new_en        (bus_wdata[0]),
        .new_load_mode (bus_wdata[21:20]),
        .int_en        (cfg.int_en),
        .set_fd        (set_frame_done),
        .set_pd        (set_palette_done),
        .set_se        (set_sync_error),
        .run_en        (run_en),
        .start_pulse   (start_pulse),
        .stop_pulse    (stop_pulse),
        .frame_done    (fd),
        .palette_done  (pd),
        .sync_err      (se),
        .irq           (irq)
    );

    panel_csr_rdmux u_rdmux (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_en        (rd_en),
        .rd_sel       (sel),
        .cfg          (cfg),
        .run_en       (run_en),
        .frame_done   (fd),
        .palette_done (pd),
        .sync_err     (se),
        .rdata        (bus_rdata),
        .rvalid       (bus_rvalid)
    );

    // Bring the decoded fields out to the panel logic.
    always_comb begin
        load_mode = cfg.load_mode;
        tft_sel   = cfg.tft;
        mono_sel  = cfg.mono;
        width_m1  = cfg.width_m1;
        height_m1 = cfg.height_m1;
    end

endmodule

// File: tb/panel_csr_tb.sv
// Scoreboard bench: read tasks queue expected words, a monitor compares responses.
module panel_csr_tb;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        set_fd = 1'b0, set_pd = 1'b0, set_se = 1'b0;
    logic [1:0]  load_mode;
    logic        tft_sel, mono_sel, run_en, start_pulse, stop_pulse, irq;
    logic [9:0]  width_m1, height_m1;

    int total = 0;
    int bad = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    panel_csr u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_rvalid(bus_rvalid), .set_frame_done(set_fd),
        .set_palette_done(set_pd), .set_sync_error(set_se),
        .load_mode(load_mode), .tft_sel(tft_sel), .mono_sel(mono_sel),
        .width_m1(width_m1), .height_m1(height_m1), .run_en(run_en),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare each read response with the head of the scoreboard.
    always @(negedge clk) begin
        if (rst_n && bus_rvalid) begin
            if (exp_q.size() == 0) begin
                total++; bad++;
                $display("FAIL R2: actual=unexpected rvalid expected=none");
            end else begin
                check(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [31:0] e, input string req);
        exp_q.push_back(e); tag_q.push_back(req);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        @(negedge clk);
    endtask

    task automatic pulse_set(input int which);
        if (which == 0) set_fd = 1'b1;
        else if (which == 1) set_pd = 1'b1;
        else set_se = 1'b1;
        @(negedge clk);
        set_fd = 1'b0; set_pd = 1'b0; set_se = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #(CLK_PERIOD * 50000);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values and readback constants
        check("R1 irq", {31'd0, irq}, 32'd0);
        check("R1 pulses", {30'd0, start_pulse, stop_pulse}, 32'd0);
        rd(8'h00, 32'hFE000C34, "R1 ctrl");
        rd(8'h04, 32'h0000000F, "R1 tim0");
        rd(8'h08, 32'h00000000, "R1 tim1");
        rd(8'h0C, 32'hFC000000, "R1 tim2");
        rd(8'h10, 32'h00000000, "R1 status");
        rd(8'h14, 32'h00000000, "R1 subp");

        // R4 / R5 / R6: timing and subpanel
        wr(8'h04, 32'h12345678);
        check("R2 no rvalid on write", {31'd0, bus_rvalid}, 32'd0);
        wr(8'h08, 32'h00000A05);
        wr(8'h0C, 32'h01234567);
        wr(8'h14, 32'hFFFFFFFF);
        check("R4 width_m1", {22'd0, width_m1}, 32'h278);
        check("R4 height_m1", {22'd0, height_m1}, 32'h205);
        rd(8'h04, 32'h1234567F, "R4 tim0");
        rd(8'h08, 32'h00000A05, "R4 tim1");
        rd(8'h0C, 32'hFD234567, "R5 tim2");
        rd(8'h14, 32'hA1FFFFFF, "R6 subp");

        // R3: control decode, enable left at 0 so no pulse
        wr(8'h00, 32'hFFFFFFFE);
        check("R8 no pulse", {30'd0, start_pulse, stop_pulse}, 32'd0);
        check("R3 fields", {28'd0, load_mode, tft_sel, mono_sel}, 32'hF);
        rd(8'h00, 32'hFFFFFFBE, "R3 ctrl all");
        wr(8'h00, 32'h00000D00);
        rd(8'h00, 32'hFE000D34, "R3 ctrl keep mask");

        // R8: enable transition
        wr(8'h00, 32'h00000019);
        check("R8 start", {30'd0, start_pulse, stop_pulse}, 32'h2);
        check("R8 run_en", {31'd0, run_en}, 32'd1);
        @(negedge clk);
        check("R8 start one cycle", {31'd0, start_pulse}, 32'd0);
        wr(8'h00, 32'h00000019);
        check("R8 same enable no pulse", {30'd0, start_pulse, stop_pulse}, 32'd0);
        rd(8'h00, 32'hFE000C3D, "R3 ctrl enabled");

        // R13 / R11 / R7: flags and interrupt
        pulse_set(0);
        check("R11 irq frame", {31'd0, irq}, 32'd1);
        rd(8'h10, 32'h00000001, "R13 fd");
        wr(8'h10, 32'hFFFFFFFF);
        rd(8'h10, 32'h00000001, "R7 status write ignored");
        pulse_set(1);
        rd(8'h10, 32'h00000041, "R13 pd");
        wr(8'h00, 32'h00000001);
        check("R11 masked", {31'd0, irq}, 32'd0);
        wr(8'h00, 32'h00000011);
        check("R11 palette enable", {31'd0, irq}, 32'd1);
        wr(8'h00, 32'h00000001);
        pulse_set(2);
        check("R11 sync unmasked", {31'd0, irq}, 32'd1);
        rd(8'h10, 32'h00000045, "R7 status layout");

        // R9: disable with load mode 0
        wr(8'h00, 32'h00000000);
        check("R8 stop", {30'd0, start_pulse, stop_pulse}, 32'h1);
        rd(8'h10, 32'h00000041, "R9 disable clears sync");
        check("R11 irq after disable", {31'd0, irq}, 32'd0);

        // R10: enable clears done flags; R9: disable with load mode 1
        wr(8'h00, 32'h00000001);
        rd(8'h10, 32'h00000000, "R10 start clears");
        wr(8'h00, 32'h00100000);
        check("R9 stop lm1", {31'd0, stop_pulse}, 32'd1);
        rd(8'h10, 32'h00000000, "R9 lm1 no frame done");

        // R12: unknown and misaligned offsets
        wr(8'h20, 32'hFFFFFFFF);
        wr(8'h15, 32'h00000000);
        wr(8'h01, 32'hFFFFFFFF);
        rd(8'h20, 32'h00000000, "R12 unknown read");
        rd(8'h16, 32'h00000000, "R12 misaligned read");
        rd(8'h14, 32'hA1FFFFFF, "R12 subp kept");
        rd(8'h00, 32'hFE100C34, "R12 ctrl kept");
        check("R12 run_en kept", {31'd0, run_en}, 32'd0);

        repeat (2) @(negedge clk);
        if (exp_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R2: actual=%0d pending expected=0", exp_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule